// File: doc/BRIEF.md
# Shared Interrupt Router with Processor Signalling

This block is the distribution stage of an interrupt controller for a small multiprocessor with 1 to 8 CPUs. Shared interrupt sources, numbered from ID 32 upward, are latched into a small per-line state machine. Each latched line is then steered to the CPUs according to a 32-bit target register that software writes through a simple word-write port. A target can name a single CPU, or it can select automatic mode, in which every CPU sees the line. A line cannot be sent to an arbitrary group of CPUs. A global enable bit masks all shared delivery. The latched state is kept while the enable bit is clear.

The same write port also carries a signal register. One write to it names a private interrupt ID and a mask of CPUs. Each masked CPU then gets a one-cycle pulse on that private ID, which its own pending logic takes as an edge event. By convention, private ID 15 is kept for processor-to-processor signalling. The hardware does not restrict which ID is used. Claiming and prioritising interrupts happens elsewhere. This block only sees completions, and a completion of a shared ID withdraws that line from every CPU.

Each shared line runs a two-state machine:
- LINE_IDLE goes to LINE_PEND when the source is sampled high.
- LINE_PEND goes back to LINE_IDLE when a completion naming that line's ID is seen.
- In every other case the state holds.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every output bit is 0, the global enable is clear and every target register holds 0 (automatic mode).
- R2: A write to byte offset 0x000 sets the global enable from data bit 0. While the enable is clear, every bit of `shr_pend_o` is 0, but line states are kept and reappear as soon as the enable is set again.
- R3: The target register of shared ID n (n >= 32) is at byte offset 0x1000 + 4*(n-32). Line k = n-32 appears for CPU c at bit `shr_pend_o[c*NUM_SHARED + k]`.
- R4: A target with bit 31 set and a CPU number in bits [7:0] below NUM_CPU delivers a pending line to that one CPU only.
- R5: A target with bit 31 set and bits [7:0] at or above NUM_CPU delivers the line to no CPU.
- R6: A target with bit 31 clear delivers the line to all CPUs, whatever its other bits hold.
- R7: A line becomes pending at the first clock edge that samples its source high. It then stays pending, even after the source drops, until it is completed.
- R8: `cmpl_valid` with `cmpl_id` equal to 32+k returns line k to idle at that edge, which withdraws it from all CPUs. Completions of any other ID leave line k untouched. A source still held high re-latches the line at the following edge.
- R9: A write to byte offset 0x040 takes a private ID from data bits [3:0] and a CPU mask from bits [15:8]. For every masked CPU c < NUM_CPU, bit `ipi_o[c*16 + id]` is high for exactly the one cycle after the write edge. Mask bits at or above NUM_CPU are ignored.
- R10: Signal-register pulses are produced whether or not the global enable is set.
- R11: Writes to unmapped offsets, to target offsets that are not word aligned, or to target offsets past the last implemented line change no state.
- R12: A change to a target register re-steers a line that is already pending, starting from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| shr_src | input | NUM_SHARED | Shared interrupt sources, line k is ID 32+k |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_id | input | 8 | Interrupt ID being completed |
| shr_pend_o | output | NUM_CPU*NUM_SHARED | Per-CPU shared pending vectors |
| ipi_o | output | NUM_CPU*16 | Per-CPU private interrupt pulses |

## Verification
The bench builds the router with NUM_CPU = 3 and NUM_SHARED = 8. With three CPUs, a single-target CPU number of 3 is out of range, and the fourth bit of the signalling mask names a CPU that does not exist, so the R5 and R9 boundaries can be reached. With only eight lines, a write to offset 0x1020 lands just past the last target register. That lets the bench check that writes beyond the array are dropped while ordinary line numbers remain easy to read in the expected vectors.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam logic [15:0] OFS_CTRL        = 16'h0000;
    localparam logic [15:0] OFS_SIGNAL      = 16'h0040;
    localparam logic [3:0]  TGT_PAGE        = 4'h1;
    localparam int unsigned FIRST_SHARED_ID = 32;
    localparam int unsigned PRIV_IDS        = 16;

    typedef enum logic [0:0] {
        LINE_IDLE = 1'b0,
        LINE_PEND = 1'b1
    } line_state_e;

    typedef enum logic [1:0] {
        RT_ALL  = 2'd0,
        RT_ONE  = 2'd1,
        RT_NONE = 2'd2
    } route_kind_e;

    function automatic route_kind_e classify(input logic [31:0] tgt, input int unsigned ncpu);
        if (!tgt[31]) begin
            return RT_ALL;
        end else if (32'(tgt[7:0]) < ncpu) begin
            return RT_ONE;
        end
        return RT_NONE;
    endfunction

endpackage

// File: rtl/sirq_line.sv
module sirq_line
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic pend_o
);

    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE: if (src_i) state_d = LINE_PEND;
            LINE_PEND: if (clr_i) state_d = LINE_IDLE;
            default:   state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == LINE_PEND);
    end

    AST_LINE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && src_i) |=> pend_o); // R7
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o); // R7
    AST_LINE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i) |=> !pend_o); // R8

endmodule

// File: rtl/sirq_route.sv
module sirq_route
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4
) (
    input  logic [31:0]        tgt_i,
    output logic [NUM_CPU-1:0] cpu_mask_o
);

    logic unused_bits;
    assign unused_bits = ^tgt_i[30:8];

    always_comb begin
        unique case (classify(tgt_i, NUM_CPU))
            RT_ALL:  cpu_mask_o = '1;
            RT_ONE:  cpu_mask_o = NUM_CPU'(1) << tgt_i[7:0];
            default: cpu_mask_o = '0;
        endcase
    end

endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_CPU    = 4,
    parameter int unsigned NUM_SHARED = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [15:0]                  wr_addr,
    input  logic [31:0]                  wr_data,
    output logic                         dist_en_o,
    output logic [31:0]                  tgt_o [NUM_SHARED],
    output logic [NUM_CPU*PRIV_IDS-1:0]  ipi_o
);

    localparam int unsigned IDX_W = 10;

    logic             hit_ctrl, hit_sig, hit_tgt;
    logic [IDX_W-1:0] tgt_idx;

    assign tgt_idx  = wr_addr[11:2];
    assign hit_ctrl = wr_en && (wr_addr == OFS_CTRL);
    assign hit_sig  = wr_en && (wr_addr == OFS_SIGNAL);
    assign hit_tgt  = wr_en && (wr_addr[15:12] == TGT_PAGE) && (wr_addr[1:0] == 2'b00)
                      && (32'(tgt_idx) < NUM_SHARED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dist_en_o <= 1'b0;
        end else if (hit_ctrl) begin
            dist_en_o <= wr_data[0];
        end
    end

    for (genvar k = 0; k < NUM_SHARED; k++) begin : g_tgt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tgt_o[k] <= 32'h0;
            end else if (hit_tgt && (tgt_idx == IDX_W'(k))) begin
                tgt_o[k] <= wr_data;
            end
        end

        AST_TGT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(hit_tgt && (tgt_idx == IDX_W'(k))) |=> $stable(tgt_o[k])); // R11
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_ipi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ipi_o[c*PRIV_IDS +: PRIV_IDS] <= '0;
            end else if (hit_sig && wr_data[8+c]) begin
                ipi_o[c*PRIV_IDS +: PRIV_IDS] <= PRIV_IDS'(1) << wr_data[3:0];
            end else begin
                ipi_o[c*PRIV_IDS +: PRIV_IDS] <= '0;
            end
        end

        AST_IPI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            ((ipi_o[c*PRIV_IDS +: PRIV_IDS] != '0) && !hit_sig)
            |=> (ipi_o[c*PRIV_IDS +: PRIV_IDS] == '0)); // R9
    end

endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_CPU    = 4,
    parameter int unsigned NUM_SHARED = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [15:0]                    wr_addr,
    input  logic [31:0]                    wr_data,
    input  logic [NUM_SHARED-1:0]          shr_src,
    input  logic                           cmpl_valid,
    input  logic [7:0]                     cmpl_id,
    output logic [NUM_CPU*NUM_SHARED-1:0]  shr_pend_o,
    output logic [NUM_CPU*PRIV_IDS-1:0]    ipi_o
);

    logic        dist_en;
    logic [31:0] tgt_w [NUM_SHARED];

    sirq_regs #(
        .NUM_CPU    (NUM_CPU),
        .NUM_SHARED (NUM_SHARED)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dist_en_o (dist_en),
        .tgt_o     (tgt_w),
        .ipi_o     (ipi_o)
    );

    for (genvar k = 0; k < NUM_SHARED; k++) begin : g_line
        logic               clr, pend;
        logic [NUM_CPU-1:0] mask, seen;

        assign clr = cmpl_valid && (cmpl_id == 8'(FIRST_SHARED_ID + k));

        sirq_line i_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (shr_src[k]),
            .clr_i  (clr),
            .pend_o (pend)
        );

        sirq_route #(
            .NUM_CPU (NUM_CPU)
        ) i_route (
            .tgt_i      (tgt_w[k]),
            .cpu_mask_o (mask)
        );

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            assign shr_pend_o[c*NUM_SHARED + k] = dist_en && pend && mask[c];
            assign seen[c] = shr_pend_o[c*NUM_SHARED + k];
        end

        AST_SINGLE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_w[k][31] |-> $onehot0(seen)); // R4
        AST_NO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_w[k][31] && (32'(tgt_w[k][7:0]) >= NUM_CPU)) |-> (seen == '0)); // R5
    end

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en |-> (shr_pend_o == '0)); // R2

endmodule

// File: tb/test_shared_irq_router.sv
`timescale 1ns/1ps
module test_shared_irq_router;

    localparam int unsigned NCPU = 3;
    localparam int unsigned NSHR = 8;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [7:0]  src;
        logic        cv;
        logic [7:0]  cid;
        logic [23:0] exp_pend;
        logic [47:0] exp_ipi;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 22;
    localparam step_t TBL [NSTEP] = '{
        '{1'b1, 16'h0000, 32'h1,         8'h00, 1'b0, 8'h00, 24'h000000, 48'h0,            4'd2},  // R2 enable
        '{1'b0, 16'h0000, 32'h0,         8'h01, 1'b0, 8'h00, 24'h010101, 48'h0,            4'd6},  // R6 R7 auto after reset
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b0, 8'h00, 24'h010101, 48'h0,            4'd7},  // R7 held
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b1, 8'h20, 24'h000000, 48'h0,            4'd8},  // R8 complete
        '{1'b1, 16'h1008, 32'h8000_0001, 8'h04, 1'b0, 8'h00, 24'h000400, 48'h0,            4'd4},  // R3 R4
        '{1'b1, 16'h1008, 32'h8000_0003, 8'h00, 1'b0, 8'h00, 24'h000000, 48'h0,            4'd5},  // R5 R12
        '{1'b1, 16'h1008, 32'h0000_0005, 8'h00, 1'b0, 8'h00, 24'h040404, 48'h0,            4'd6},  // R6 R12
        '{1'b1, 16'h0000, 32'h0,         8'h00, 1'b0, 8'h00, 24'h000000, 48'h0,            4'd2},  // R2 off
        '{1'b1, 16'h0000, 32'h1,         8'h00, 1'b0, 8'h00, 24'h040404, 48'h0,            4'd2},  // R2 kept
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b1, 8'h02, 24'h040404, 48'h0,            4'd8},  // R8 low ID
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b1, 8'h23, 24'h040404, 48'h0,            4'd8},  // R8 other line
        '{1'b1, 16'h100A, 32'h8000_0000, 8'h00, 1'b0, 8'h00, 24'h040404, 48'h0,            4'd11}, // R11 misaligned
        '{1'b1, 16'h1020, 32'h8000_0000, 8'h00, 1'b0, 8'h00, 24'h040404, 48'h0,            4'd11}, // R11 past end
        '{1'b1, 16'h0080, 32'h0,         8'h00, 1'b0, 8'h00, 24'h040404, 48'h0,            4'd11}, // R11 unmapped
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b1, 8'h22, 24'h000000, 48'h0,            4'd8},  // R8
        '{1'b1, 16'h0040, 32'h0000_0A0F, 8'h00, 1'b0, 8'h00, 24'h000000, 48'h0000_8000_0000, 4'd9}, // R9
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b0, 8'h00, 24'h000000, 48'h0,            4'd9},  // R9 one cycle
        '{1'b1, 16'h0000, 32'h0,         8'h00, 1'b0, 8'h00, 24'h000000, 48'h0,            4'd10}, // R10 off
        '{1'b1, 16'h0040, 32'h0000_0703, 8'h00, 1'b0, 8'h00, 24'h000000, 48'h0008_0008_0008, 4'd10}, // R10
        '{1'b1, 16'h1014, 32'h8000_0000, 8'h20, 1'b0, 8'h00, 24'h000000, 48'h0,            4'd2},  // R2 masked
        '{1'b1, 16'h0000, 32'h1,         8'h20, 1'b0, 8'h00, 24'h000020, 48'h0,            4'd4},  // R4 CPU0
        '{1'b0, 16'h0000, 32'h0,         8'h00, 1'b1, 8'h25, 24'h000000, 48'h0,            4'd8}   // R8
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_en = 1'b0;
    logic [15:0]            wr_addr = '0;
    logic [31:0]            wr_data = '0;
    logic [NSHR-1:0]        shr_src = '0;
    logic                   cmpl_valid = 1'b0;
    logic [7:0]             cmpl_id = '0;
    logic [NCPU*NSHR-1:0]   shr_pend_o;
    logic [NCPU*16-1:0]     ipi_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shared_irq_router #(
        .NUM_CPU    (NCPU),
        .NUM_SHARED (NSHR)
    ) i_shared_irq_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .shr_src    (shr_src),
        .cmpl_valid (cmpl_valid),
        .cmpl_id    (cmpl_id),
        .shr_pend_o (shr_pend_o),
        .ipi_o      (ipi_o)
    );

    task automatic drive(input logic wr, input logic [15:0] a, input logic [31:0] d,
                         input logic [7:0] s, input logic cv, input logic [7:0] cid);
        @(negedge clk);
        wr_en = wr; wr_addr = a; wr_data = d; shr_src = s; cmpl_valid = cv; cmpl_id = cid;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [23:0] ep, input logic [47:0] ei, input string tag);
        checks++;
        if (shr_pend_o !== ep || ipi_o !== ei) begin
            errors++;
            $display("FAIL %s pend=%h ipi=%h expected pend=%h ipi=%h", tag, shr_pend_o, ipi_o, ep, ei);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #12;
        check(24'h0, 48'h0, "R1 reset outputs");
        rst_n = 1'b1;
        for (int i = 0; i < NSTEP; i++) begin
            drive(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].src, TBL[i].cv, TBL[i].cid);
            check(TBL[i].exp_pend, TBL[i].exp_ipi, $sformatf("R%0d step %0d", TBL[i].req, i));
        end
        // R7 R8: source held high across a completion
        drive(1'b0, 16'h0, 32'h0, 8'h02, 1'b0, 8'h00);
        check(24'h020202, 48'h0, "R7 held source latch");
        drive(1'b0, 16'h0, 32'h0, 8'h02, 1'b1, 8'h21);
        check(24'h000000, 48'h0, "R8 completion gap");
        drive(1'b0, 16'h0, 32'h0, 8'h02, 1'b0, 8'h00);
        check(24'h020202, 48'h0, "R8 relatch while high");
        drive(1'b0, 16'h0, 32'h0, 8'h00, 1'b1, 8'h21);
        check(24'h000000, 48'h0, "R8 final clear");
        // R1: reset restores automatic mode on a routed line
        drive(1'b1, 16'h1008, 32'h8000_0000, 8'h00, 1'b0, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        #1;
        check(24'h0, 48'h0, "R1 reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 16'h0000, 32'h1, 8'h04, 1'b0, 8'h00);
        check(24'h040404, 48'h0, "R1 target back to auto");
        drive(1'b0, 16'h0, 32'h0, 8'h00, 1'b1, 8'h22);
        check(24'h0, 48'h0, "R8 cleanup");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule